// File: doc/BRIEF.md
# Prescaled Cycle Counter with Privilege-Gated Prohibit

This block keeps a 64-bit count of processor clock cycles for a performance-monitoring unit. On each clock it decides whether the count may advance. That decision draws on a global enable, the counter's own enable, the current privilege level, the security state, and several prohibit and cycle-disable bits. These bits come from the monitor-level and hypervisor-level debug control registers.

The count can advance on every permitted clock, or once every 64 permitted clocks through a 6-bit prescaler. Selecting the long (64-bit) overflow mode cancels the prescaler, even when divide is requested. Software may load all 64 bits at any time. The overflow output is a one-clock pulse that the surrounding unit turns into status bit 31. It marks a wrap at the 32-bit boundary in short mode, or at the 64-bit boundary in long mode.

Top module: `cycle_tally`

## Requirements
- R1: During and after a synchronous active-low reset, `count` is 0 and `ovf_pulse` is 0.
- R2: When counting is permitted and the divider is inactive, `count` rises by exactly 1 on each clock. Without a write it never changes by more than 1 in one clock.
- R3: With `div_sel`=1 and `long_mode`=0, the count rises once per 64 permitted clocks. The first rise comes on the 64th permitted clock after the prescaler is cleared.
- R4: With `long_mode`=1, `div_sel` has no effect, and a permitted count rises on every clock.
- R5: The count advances only when both `glob_en` and `cnt_en` are 1.
- R6: An event prohibit exists when `cur_level`==2'd2 (hypervisor level) and `hyp_prohib`=1, or when `secure`=1 and `mon_allow`=0. Such a prohibit stops the counter only when `dis_on_prohib`=1.
- R7: With parameter EXT_CYC_DIS=1, the counter stops when `secure`=1 and `mon_cyc_dis`=1. It also stops when `cur_level`==2'd2 and `hyp_cyc_dis`=1. Both stops apply whatever the value of `dis_on_prohib`.
- R8: `wr_en`=1 loads all 64 bits of `wr_data` on that clock, taking priority over counting. It also clears the prescaler.
- R9: With `long_mode`=0, an increment from a value whose low 32 bits are all ones raises `ovf_pulse` for exactly one clock, together with the new count. The carry still propagates into the upper 32 bits.
- R10: With `long_mode`=1, the pulse fires only on the wrap from all ones to 0. Crossing the 32-bit boundary gives no pulse.
- R11: Any change of the effective divide mode (`div_sel` and not `long_mode`) clears the prescaler. After a return to divide mode, the next rise needs a full 64 permitted clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_en | input | 1 | Global counter enable |
| cnt_en | input | 1 | Cycle counter enable (bit 31 of the enable set) |
| div_sel | input | 1 | Request divide-by-64 |
| long_mode | input | 1 | 64-bit overflow mode; cancels divide |
| dis_on_prohib | input | 1 | Stop the cycle counter when event counting is prohibited |
| hyp_prohib | input | 1 | Hypervisor-level event prohibit |
| mon_allow | input | 1 | Secure event counting allowed by monitor |
| mon_cyc_dis | input | 1 | Monitor cycle-counter disable in secure state |
| hyp_cyc_dis | input | 1 | Hypervisor cycle-counter disable at level 2 |
| cur_level | input | 2 | Current privilege level, 2'd2 = hypervisor |
| secure | input | 1 | Current security state is secure |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Software write value |
| count | output | 64 | Current count |
| ovf_pulse | output | 1 | One-clock overflow indication for status bit 31 |

## Verification
The bench sweeps every combination of level, security state, both prohibit sources, DP and the two cycle-disable bits. It finds any term missing from the stop chain, or any term that wrongly requires DP; either fault shows as a counter that advances or stalls in the wrong case. It drives both overflow boundaries in both modes. A design that tests the wrong bit would pulse at the 32-bit crossing in long mode, or would miss the carry into the upper half. The divider is checked at exactly 63 and 64 permitted clocks, including after a write and after a brief switch into long mode. A prescaler that is not cleared would then rise early.

// File: rtl/cycle_tally_pkg.sv
// Package: shared types for the cycle tally block.
// Assumes privilege level 2 is the hypervisor level.
package cycle_tally_pkg;

    // Privilege levels as seen on cur_level
    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } lvl_e;

    // Debug-control bits that can stop the cycle counter
    typedef struct packed {
        logic dis_on_prohib;
        logic hyp_prohib;
        logic mon_allow;
        logic mon_cyc_dis;
        logic hyp_cyc_dis;
    } guard_t;

endpackage

// File: rtl/cyc_gate.sv
// Module: cyc_gate
// Decides, purely combinationally, whether the cycle counter may
// advance this clock. Assumes all inputs are stable registered state.
module cyc_gate
    import cycle_tally_pkg::*;
#(
    parameter bit EXT_CYC_DIS = 1'b1
) (
    input  logic       glob_en,
    input  logic       cnt_en,
    input  guard_t     guard,
    input  logic [1:0] cur_level,
    input  logic       secure,
    output logic       count_ok
);

    logic at_hyp;
    logic evt_prohib;
    logic cyc_stop;

    // Level decode and event-prohibit sources
    always_comb begin
        at_hyp     = (lvl_e'(cur_level) == LVL_HYP);
        evt_prohib = (at_hyp && guard.hyp_prohib) || (secure && !guard.mon_allow);
    end

    // Cycle-only disables exist only when the extension is built in
    generate
        if (EXT_CYC_DIS) begin : g_ext
            always_comb cyc_stop = (secure && guard.mon_cyc_dis) ||
                                   (at_hyp && guard.hyp_cyc_dis);
        end else begin : g_noext
            always_comb cyc_stop = 1'b0;
        end
    endgenerate

    // Final permission: enables, then DP-qualified prohibit, then cycle stops
    always_comb begin
        count_ok = glob_en && cnt_en &&
                   !(evt_prohib && guard.dis_on_prohib) &&
                   !cyc_stop;
    end

endmodule

// File: rtl/cyc_prescale.sv
// Module: cyc_prescale
// Produces the increment tick. In divide mode it emits one tick per
// 2**PRESC_W permitted clocks; otherwise one per permitted clock.
// Assumes a write or a change of effective divide mode restarts the count.
module cyc_prescale #(
    parameter int PRESC_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_sel,
    input  logic long_mode,
    input  logic count_ok,
    input  logic wr_en,
    output logic tick
);

    localparam logic [PRESC_W-1:0] PRESC_LAST = {PRESC_W{1'b1}};

    logic               div_active;
    logic               div_q;
    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] presc_eff;
    logic [PRESC_W-1:0] presc_d;

    // Effective divide mode: long mode cancels the divider
    always_comb div_active = div_sel && !long_mode;

    // Prescaler value seen this clock, zero on a mode change
    always_comb presc_eff = (div_active != div_q) ? '0 : presc_q;

    // Tick and next prescaler value
    always_comb begin
        tick    = count_ok && (!div_active || (presc_eff == PRESC_LAST));
        presc_d = presc_eff;
        if (wr_en) begin
            presc_d = '0;
        end else if (count_ok && div_active) begin
            presc_d = presc_eff + 1'b1;
        end
    end

    // Prescaler and mode history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            div_q   <= 1'b0;
        end else begin
            presc_q <= presc_d;
            div_q   <= div_active;
        end
    end

endmodule

// File: rtl/cyc_accum.sv
// Module: cyc_accum
// Holds the count, applies writes and ticks, and flags a wrap at the
// short or long boundary. Assumes CNT_W is larger than LOW_W.
module cyc_accum #(
    parameter int CNT_W = 64,
    parameter int LOW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             long_mode,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             ovf_pulse
);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             low_full;
    logic             all_full;
    logic             wraps;

    // Boundary detection on the current value
    always_comb begin
        low_full = &cnt_q[LOW_W-1:0];
        all_full = &cnt_q;
        wraps    = long_mode ? all_full : low_full;
    end

    // Count register: write wins over tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_data;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Overflow pulse, one clock, aligned with the wrapped value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= !wr_en && tick && wraps;
        end
    end

    assign count     = cnt_q;
    assign ovf_pulse = ovf_q;

endmodule

// File: rtl/cycle_tally.sv
// Module: cycle_tally (top)
// 64-bit cycle counter with a divide-by-64 prescaler, long overflow mode
// and a layered prohibit chain. Assumes all control inputs are synchronous.
module cycle_tally
    import cycle_tally_pkg::*;
#(
    parameter int CNT_W       = 64,
    parameter int LOW_W       = 32,
    parameter int PRESC_W     = 6,
    parameter bit EXT_CYC_DIS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_en,
    input  logic             cnt_en,
    input  logic             div_sel,
    input  logic             long_mode,
    input  logic             dis_on_prohib,
    input  logic             hyp_prohib,
    input  logic             mon_allow,
    input  logic             mon_cyc_dis,
    input  logic             hyp_cyc_dis,
    input  logic [1:0]       cur_level,
    input  logic             secure,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             ovf_pulse
);

    guard_t guard;
    logic   count_ok;
    logic   tick;

    // Collect the guard bits
    always_comb begin
        guard.dis_on_prohib = dis_on_prohib;
        guard.hyp_prohib    = hyp_prohib;
        guard.mon_allow     = mon_allow;
        guard.mon_cyc_dis   = mon_cyc_dis;
        guard.hyp_cyc_dis   = hyp_cyc_dis;
    end

    cyc_gate #(.EXT_CYC_DIS(EXT_CYC_DIS)) u_gate (
        .glob_en   (glob_en),
        .cnt_en    (cnt_en),
        .guard     (guard),
        .cur_level (cur_level),
        .secure    (secure),
        .count_ok  (count_ok)
    );

    cyc_prescale #(.PRESC_W(PRESC_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_sel   (div_sel),
        .long_mode (long_mode),
        .count_ok  (count_ok),
        .wr_en     (wr_en),
        .tick      (tick)
    );

    cyc_accum #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .long_mode (long_mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .count     (count),
        .ovf_pulse (ovf_pulse)
    );

endmodule

// File: rtl/cycle_tally_chk.sv
// Module: cycle_tally_chk
// Temporal checks on the cycle tally ports, bound into the top.
module cycle_tally_chk #(
    parameter int CNT_W       = 64,
    parameter int LOW_W       = 32,
    parameter bit EXT_CYC_DIS = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glob_en,
    input logic             cnt_en,
    input logic             div_sel,
    input logic             long_mode,
    input logic             dis_on_prohib,
    input logic             hyp_prohib,
    input logic             mon_allow,
    input logic             mon_cyc_dis,
    input logic             hyp_cyc_dis,
    input logic [1:0]       cur_level,
    input logic             secure,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count,
    input logic             ovf_pulse
);

    // R1: held in reset means zero outputs
    a_r1_reset_zero: assert property (@(posedge clk)
        !$past(rst_n) |-> (count == '0 && !ovf_pulse));

    // R2: without a write the count moves by at most one
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (count == $past(count) || count == $past(count) + 1'b1));

    // R3: in divide mode two rises are never adjacent
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && div_sel && !long_mode && count != $past(count)) |=> count == $past(count));

    // R4: long mode with no prohibit source counts every clock
    a_r4_long_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && long_mode && glob_en && cnt_en && !secure && cur_level != 2'd2)
        |=> count == $past(count) + 1'b1);

    // R5: either enable low holds the count
    a_r5_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(glob_en && cnt_en)) |=> count == $past(count));

    // R6: DP-qualified prohibits hold the count
    a_r6_prohib_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && dis_on_prohib &&
         ((secure && !mon_allow) || (cur_level == 2'd2 && hyp_prohib)))
        |=> count == $past(count));

    // R7: cycle-only disables hold the count regardless of DP
    a_r7_cyc_dis_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (EXT_CYC_DIS && !wr_en &&
         ((secure && mon_cyc_dis) || (cur_level == 2'd2 && hyp_cyc_dis)))
        |=> count == $past(count));

    // R8: a write lands on the next clock
    a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> count == $past(wr_data));

    // R9/R10: a pulse only accompanies a value just past the boundary
    a_r9_ovf_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ($past(long_mode) ? (count == '0) : (count[LOW_W-1:0] == '0)));

    // R9: the pulse lasts one clock
    a_r9_ovf_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

endmodule

bind cycle_tally cycle_tally_chk #(
    .CNT_W(CNT_W), .LOW_W(LOW_W), .EXT_CYC_DIS(EXT_CYC_DIS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cnt_en(cnt_en),
    .div_sel(div_sel), .long_mode(long_mode), .dis_on_prohib(dis_on_prohib),
    .hyp_prohib(hyp_prohib), .mon_allow(mon_allow), .mon_cyc_dis(mon_cyc_dis),
    .hyp_cyc_dis(hyp_cyc_dis), .cur_level(cur_level), .secure(secure),
    .wr_en(wr_en), .wr_data(wr_data), .count(count), .ovf_pulse(ovf_pulse)
);

// File: tb/sim_cycle_tally.sv
module sim_cycle_tally;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        glob_en, cnt_en, div_sel, long_mode, dis_on_prohib;
    logic        hyp_prohib, mon_allow, mon_cyc_dis, hyp_cyc_dis;
    logic [1:0]  cur_level;
    logic        secure, wr_en;
    logic [63:0] wr_data;
    logic [63:0] count;
    logic        ovf_pulse;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cycle_tally u0 (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cnt_en(cnt_en),
        .div_sel(div_sel), .long_mode(long_mode), .dis_on_prohib(dis_on_prohib),
        .hyp_prohib(hyp_prohib), .mon_allow(mon_allow), .mon_cyc_dis(mon_cyc_dis),
        .hyp_cyc_dis(hyp_cyc_dis), .cur_level(cur_level), .secure(secure),
        .wr_en(wr_en), .wr_data(wr_data), .count(count), .ovf_pulse(ovf_pulse)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model, from the requirements
    logic [63:0] m_cnt;
    logic        m_ovf;
    int          m_pre;
    bit          m_div_q;

    function automatic bit permitted();
        bit hyp, prohib, stop;
        hyp    = (cur_level == 2'd2);
        prohib = (hyp && hyp_prohib) || (secure && !mon_allow);
        stop   = (secure && mon_cyc_dis) || (hyp && hyp_cyc_dis);
        return glob_en && cnt_en && !(prohib && dis_on_prohib) && !stop;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_ovf = 1'b0; m_pre = 0; m_div_q = 1'b0;
        end else begin
            bit div, ok, inc;
            int pv;
            div = div_sel && !long_mode;
            pv  = (div != m_div_q) ? 0 : m_pre;
            ok  = permitted();
            inc = ok && (!div || pv == 63);
            m_ovf = 1'b0;
            if (wr_en) begin
                m_cnt = wr_data;
                m_pre = 0;
            end else begin
                if (inc) begin
                    m_ovf = long_mode ? (m_cnt == 64'hFFFF_FFFF_FFFF_FFFF)
                                      : (m_cnt[31:0] == 32'hFFFF_FFFF);
                    m_cnt = m_cnt + 64'd1;
                end
                m_pre = (ok && div) ? (pv + 1) % 64 : pv;
            end
            m_div_q = div;
        end
    end

    // Per-clock comparison against the model (R2, R3, R9 and others)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            check(count === m_cnt, "R2 model count", count, m_cnt);
            check(ovf_pulse === m_ovf, "R9 model ovf", {63'd0, ovf_pulse}, {63'd0, m_ovf});
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [63:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic open_all();
        glob_en = 1; cnt_en = 1; div_sel = 0; long_mode = 0; dis_on_prohib = 0;
        hyp_prohib = 0; mon_allow = 1; mon_cyc_dis = 0; hyp_cyc_dis = 0;
        cur_level = 2'd1; secure = 0;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [63:0] c0;
        open_all();
        glob_en = 0; wr_en = 0; wr_data = '0; rst_n = 0;
        run(4);
        // R1: reset state
        check(count == 0 && !ovf_pulse, "R1 reset", count, 64'd0);
        rst_n = 1;
        run(2);
        check(count == 0, "R5 disabled after reset", count, 64'd0);

        // R2: plain counting
        open_all();
        run(10);
        check(count == 64'd10, "R2 ten clocks", count, 64'd10);

        // R5: either enable off
        cnt_en = 0; c0 = count; run(5);
        check(count == c0, "R5 cnt_en low", count, c0);
        cnt_en = 1; glob_en = 0; run(5);
        check(count == c0, "R5 glob_en low", count, c0);
        glob_en = 1;

        // R3: divide by 64 after a write
        div_sel = 1; run(2);
        write(64'd0);
        run(63);
        check(count == 64'd0, "R3 no rise at 63", count, 64'd0);
        run(1);
        check(count == 64'd1, "R3 rise at 64", count, 64'd1);
        run(64);
        check(count == 64'd2, "R3 second rise", count, 64'd2);

        // R11: mode change clears prescaler
        run(40);
        long_mode = 1; run(1);
        long_mode = 0; c0 = count; run(63);
        check(count == c0, "R11 no early rise", count, c0);
        run(1);
        check(count == c0 + 1, "R11 rise after 64", count, c0 + 1);

        // R4: long mode ignores divide
        long_mode = 1; c0 = count; run(10);
        check(count == c0 + 10, "R4 long every clock", count, c0 + 10);

        // R8: write while counting, all 64 bits
        write(64'hA5A5_0000_1234_5678);
        check(count == 64'hA5A5_0000_1234_5678, "R8 write loads", count, 64'hA5A5_0000_1234_5678);

        // R10: long mode crosses 32 bits silently, wraps at 64
        write(64'h0000_0000_FFFF_FFFF);
        run(1);
        check(count == 64'h1_0000_0000 && !ovf_pulse, "R10 no pulse at 32", count, 64'h1_0000_0000);
        write(64'hFFFF_FFFF_FFFF_FFFF);
        run(1);
        check(count == 0 && ovf_pulse, "R10 wrap pulse", {63'd0, ovf_pulse}, 64'd1);
        run(1);
        check(!ovf_pulse, "R10 pulse one clock", {63'd0, ovf_pulse}, 64'd0);

        // R9: short mode boundary with carry
        long_mode = 0; div_sel = 0;
        write(64'h0000_0000_FFFF_FFFE);
        run(1);
        check(!ovf_pulse, "R9 no pulse before", {63'd0, ovf_pulse}, 64'd0);
        run(1);
        check(count == 64'h1_0000_0000 && ovf_pulse, "R9 pulse with carry", count, 64'h1_0000_0000);
        run(1);
        check(!ovf_pulse, "R9 pulse one clock", {63'd0, ovf_pulse}, 64'd0);

        // R6/R7: sweep of the stop chain
        for (int k = 0; k < 256; k++) begin
            bit hyp, prohib, stop, adv;
            open_all();
            cur_level     = k[1:0];
            secure        = k[2];
            dis_on_prohib = k[3];
            mon_cyc_dis   = k[4];
            hyp_cyc_dis   = k[5];
            hyp_prohib    = k[6];
            mon_allow     = k[7];
            write(64'h100);
            run(3);
            hyp    = (k[1:0] == 2'd2);
            prohib = (hyp && k[6]) || (k[2] && !k[7]);
            stop   = (k[2] && k[4]) || (hyp && k[5]);
            adv    = !(prohib && k[3]) && !stop;
            if (stop)
                check(count == (adv ? 64'h103 : 64'h100), "R7 cycle disable", count, adv ? 64'h103 : 64'h100);
            else
                check(count == (adv ? 64'h103 : 64'h100), "R6 prohibit chain", count, adv ? 64'h103 : 64'h100);
        end

        summary();
    end

endmodule